// File: doc/BRIEF.md
# MII Management Slave Register File

This block is the station-management slave of a 10/100 Ethernet PHY. It runs on the management clock (MDC). It decodes serial frames that arrive on the management data line and answers them from a bank of 16-bit registers. A frame is a preamble of 32 ones, the start pattern 01, a 2-bit opcode (10 read, 01 write), a 5-bit PHY address, a 5-bit register address and a 2-bit turnaround, followed by 16 data bits. Every field is sent most significant bit first.

The PHY address is taken from strap pins while reset is held. The slave answers frames that carry this strapped address and also frames that carry address 0. A strapped address of 0 leaves the PHY isolated after reset. The implemented registers are the control word (0), the status word (1), two identifier words (2, 3), the advertisement word (4) and the address/speed word (25). The line interface, the event counters and autonegotiation are outside the block: they reach it only as status inputs. The control word is brought out on a port so that the rest of the PHY can act on it.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones on mdio_in, followed by start bits 0 then 1, and only with opcode 10 (read) or 01 (write). A frame with a shorter preamble, or with opcode 00 or 11, neither drives mdio nor changes any register.
- R2: The slave answers the address captured from the straps and address 00000. A frame for any other address neither drives mdio nor writes.
- R3: On a read, mdio_oe rises for the second turnaround period with mdio_out = 0. The 16 data bits follow MSB first, one per MDC period. mdio_oe falls after the last data bit, so it stays high for 17 periods.
- R4: Register 25 reads as bits 4:0 = strapped address, bit 6 = 1 when the 100 Mb/s bit (control bit 13) is clear, and all other bits 0.
- R5: When the strapped address is 00000, control bit 10 (isolate) is 1 on leaving reset. Otherwise the control word resets to 0x3000.
- R6: Control register 0 holds writable bits 15:7 (15 reset, 14 loopback, 13 speed 100, 12 autoneg enable, 11 power down, 10 isolate, 9 restart autoneg, 8 full duplex, 7 collision test). Bits 6:0 always read 0. The written word appears on ctrl_word after the edge that samples the last data bit.
- R7: Control bits 15 and 9 clear themselves one MDC cycle after a write sets them.
- R8: Status register 1 reads as bits 15:11 = ability parameter (default 01111), bits 10:6 = 0, bit 5 = an_complete, bit 4 = remote_fault, bit 3 = 1, bit 2 = latched link, bit 1 = jabber, bit 0 = 1.
- R9: The link bit in register 1 latches low whenever link_up is low. A read of register 1 returns the latched value and then reloads the latch with the live link_up. The latch is 0 after reset.
- R10: Register 4 is a fully writable 16-bit word that resets to 0x01E1. Writes to reserved registers (7 to 17, 29 to 31) and to the other registers that are not implemented have no effect, and those registers read 0.
- R11: Registers 2 and 3 read the identifier parameters (defaults 0x0A5C and 0x3E21).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| mdio_in | input | 1 | Serial management data from the station |
| mdio_out | output | 1 | Serial data driven back during reads |
| mdio_oe | output | 1 | Output enable for mdio_out |
| strap_addr | input | 5 | PHY address strap pins |
| an_complete | input | 1 | Autonegotiation complete status |
| remote_fault | input | 1 | Remote fault status |
| link_up | input | 1 | Live link status |
| jabber | input | 1 | Jabber condition status |
| ctrl_word | output | 16 | Current control register contents |

## Verification
A frame decoder that slips by one bit shows up in the period right after the first turnaround bit: mdio_oe rises one period early or late, or the first data bit comes out shifted. The comparison checks every period of every frame, so such a slip is found in the frame that causes it. Wrong register contents, such as a missed self-clear, a leaked write to a reserved word or a stale link latch, show on ctrl_word within one cycle of the write. Otherwise they show in the data bits of the next read of that register. A wrong strap capture shows either as a missing response at the strapped address or as a wrong isolate bit in the first period after reset.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the management slave.
// Assumes a 5-bit register address space with 16-bit registers.
package mdio_pkg;
    localparam int MDIO_AW = 5;
    localparam int MDIO_DW = 16;

    typedef logic [MDIO_AW-1:0] reg_addr_t;

    // Frame decoder states, in the order the fields arrive
    typedef enum logic [2:0] {
        FR_PRE, FR_START, FR_OP, FR_PHY, FR_REG, FR_TA1, FR_TA2, FR_DATA
    } frame_state_t;

    // Register locations whose position software depends on
    localparam reg_addr_t LOC_CTRL  = 5'd0;
    localparam reg_addr_t LOC_STAT  = 5'd1;
    localparam reg_addr_t LOC_IDHI  = 5'd2;
    localparam reg_addr_t LOC_IDLO  = 5'd3;
    localparam reg_addr_t LOC_ADV   = 5'd4;
    localparam reg_addr_t LOC_STRAP = 5'd25;

    // Control word bit positions
    localparam int CB_RESET   = 15;
    localparam int CB_SPEED   = 13;
    localparam int CB_ISOLATE = 10;
    localparam int CB_RESTART = 9;

    localparam logic [MDIO_DW-1:0] CTRL_WMASK = 16'hFF80;

    // True for the reserved windows of the address map
    function automatic logic loc_reserved(input reg_addr_t a);
        return ((a >= 5'd7) && (a <= 5'd17)) || (a >= 5'd29);
    endfunction
endpackage

// File: rtl/mdio_frame_rx.sv
// Module: serial frame decoder and read-data shifter.
// It samples mdio_in on each rising clock edge and walks through the frame
// fields. It drives mdio_out/mdio_oe for reads addressed to it, and it
// issues a one-cycle write strobe after the last data bit of a matching
// write. Assumes the station keeps to the frame layout and that the bit
// clock is the block clock.
module mdio_frame_rx
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int AW      = MDIO_AW,
    parameter int DW      = MDIO_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mdio_in,
    input  logic [AW-1:0] my_addr,
    input  logic [DW-1:0] rd_data,
    output logic          mdio_out,
    output logic          mdio_oe,
    output logic [AW-1:0] reg_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          rd_pulse
);
    localparam int PCW = $clog2(PRE_LEN + 1);
    localparam int BCW = $clog2(DW);
    localparam logic [PCW-1:0] PRE_MAX  = PCW'(PRE_LEN);
    localparam logic [BCW-1:0] AW_LAST  = BCW'(AW - 1);
    localparam logic [BCW-1:0] DW_LAST  = BCW'(DW - 1);

    frame_state_t   state;
    logic [PCW-1:0] pre_cnt;
    logic [BCW-1:0] bit_cnt;
    logic           op_hi;
    logic           is_read;
    logic           hit;
    logic [AW-1:0]  phy_sh;
    logic [AW-1:0]  reg_sh;
    logic [DW-1:0]  sh;
    logic [AW-1:0]  phy_next;
    logic           addr_hit;
    logic           read_hit;

    // Address match on the completed PHY field: own address or broadcast
    always_comb begin
        phy_next = {phy_sh[AW-2:0], mdio_in};
        addr_hit = (phy_next == my_addr) || (phy_next == '0);
        read_hit = is_read && hit;
    end

    // Strobes and data handed to the register bank
    always_comb begin
        reg_addr = reg_sh;
        wr_data  = {sh[DW-2:0], mdio_in};
        wr_en    = (state == FR_DATA) && (bit_cnt == DW_LAST) && !is_read && hit;
        rd_pulse = (state == FR_TA2) && read_hit;
    end

    // Frame field sequencer and output driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FR_PRE;
            pre_cnt  <= '0;
            bit_cnt  <= '0;
            op_hi    <= 1'b0;
            is_read  <= 1'b0;
            hit      <= 1'b0;
            phy_sh   <= '0;
            reg_sh   <= '0;
            sh       <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
        end else begin
            case (state)
                FR_PRE: begin
                    if (mdio_in) begin
                        if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
                    end else begin
                        if (pre_cnt == PRE_MAX) state <= FR_START;
                        pre_cnt <= '0;
                    end
                end
                FR_START: begin
                    bit_cnt <= '0;
                    state   <= mdio_in ? FR_OP : FR_PRE;
                end
                FR_OP: begin
                    if (bit_cnt == '0) begin
                        op_hi   <= mdio_in;
                        bit_cnt <= 1'b1;
                    end else begin
                        bit_cnt <= '0;
                        if (op_hi != mdio_in) begin
                            is_read <= op_hi;
                            state   <= FR_PHY;
                        end else begin
                            state <= FR_PRE;
                        end
                    end
                end
                FR_PHY: begin
                    phy_sh <= phy_next;
                    if (bit_cnt == AW_LAST) begin
                        bit_cnt <= '0;
                        hit     <= addr_hit;
                        state   <= FR_REG;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                FR_REG: begin
                    reg_sh <= {reg_sh[AW-2:0], mdio_in};
                    if (bit_cnt == AW_LAST) begin
                        bit_cnt <= '0;
                        state   <= FR_TA1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                FR_TA1: begin
                    if (read_hit) begin
                        mdio_oe  <= 1'b1;
                        mdio_out <= 1'b0;
                    end
                    state <= FR_TA2;
                end
                FR_TA2: begin
                    sh      <= rd_data;
                    bit_cnt <= '0;
                    if (read_hit) mdio_out <= rd_data[DW-1];
                    state   <= FR_DATA;
                end
                FR_DATA: begin
                    sh <= {sh[DW-2:0], mdio_in};
                    if (bit_cnt == DW_LAST) begin
                        mdio_oe  <= 1'b0;
                        mdio_out <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= FR_PRE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (read_hit) mdio_out <= sh[DW-2];
                    end
                end
                default: state <= FR_PRE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_regbank.sv
// Module: the management register bank.
// It holds the control and advertisement words, the strapped address and
// the latched-low link bit, and it assembles the read-only words from
// parameters and status inputs. Assumes wr_en and rd_pulse are single-cycle
// strobes from the frame decoder.
module mdio_regbank
    import mdio_pkg::*;
#(
    parameter int              AW       = MDIO_AW,
    parameter int              DW       = MDIO_DW,
    parameter logic [DW-1:0]   ID_HI    = 16'h0A5C,
    parameter logic [DW-1:0]   ID_LO    = 16'h3E21,
    parameter logic [4:0]      ABILITY  = 5'b01111,
    parameter logic [DW-1:0]   CTRL_RST = 16'h3000,
    parameter logic [DW-1:0]   ADV_RST  = 16'h01E1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] strap_addr,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_pulse,
    input  logic          an_complete,
    input  logic          remote_fault,
    input  logic          link_up,
    input  logic          jabber,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ctrl_q,
    output logic [AW-1:0] my_addr,
    output logic          link_latched
);
    logic [DW-1:0] adv_q;
    logic [DW-1:0] status_word;
    logic [DW-1:0] strap_word;
    logic          wr_ok;

    // Writes reach only non-reserved locations
    always_comb wr_ok = wr_en && !loc_reserved(addr);

    // Strap capture while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) my_addr <= strap_addr;
    end

    // Control word: reset value, masked writes, self-clearing strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            ctrl_q[CB_ISOLATE] <= CTRL_RST[CB_ISOLATE] | (strap_addr == '0);
        end else if (wr_ok && (addr == LOC_CTRL)) begin
            ctrl_q <= wr_data & CTRL_WMASK;
        end else begin
            ctrl_q[CB_RESET]   <= 1'b0;
            ctrl_q[CB_RESTART] <= 1'b0;
        end
    end

    // Advertisement word: plain read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n) adv_q <= ADV_RST;
        else if (wr_ok && (addr == LOC_ADV)) adv_q <= wr_data;
    end

    // Link latch: drops with the link, reloads after a status read
    always_ff @(posedge clk) begin
        if (!rst_n) link_latched <= 1'b0;
        else if (rd_pulse && (addr == LOC_STAT)) link_latched <= link_up;
        else if (!link_up) link_latched <= 1'b0;
    end

    // Read-only words built from inputs and parameters
    always_comb begin
        status_word = {ABILITY, 5'b0, an_complete, remote_fault, 1'b1,
                       link_latched, jabber, 1'b1};
        strap_word  = '0;
        strap_word[6]    = ~ctrl_q[CB_SPEED];
        strap_word[4:0]  = my_addr;
    end

    // Read multiplexer; unimplemented and reserved words read zero
    always_comb begin
        case (addr)
            LOC_CTRL:  rd_data = ctrl_q;
            LOC_STAT:  rd_data = status_word;
            LOC_IDHI:  rd_data = ID_HI;
            LOC_IDLO:  rd_data = ID_LO;
            LOC_ADV:   rd_data = adv_q;
            LOC_STRAP: rd_data = strap_word;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Module: top of the management slave.
// It joins the frame decoder to the register bank and brings the control
// word out for the rest of the PHY. Assumes MDC is the only clock and that
// the straps are stable while reset is held.
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter int            PRE_LEN = 32,
    parameter logic [15:0]   ID_HI   = 16'h0A5C,
    parameter logic [15:0]   ID_LO   = 16'h3E21,
    parameter logic [4:0]    ABILITY = 5'b01111
) (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic        mdio_in,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic [4:0]  strap_addr,
    input  logic        an_complete,
    input  logic        remote_fault,
    input  logic        link_up,
    input  logic        jabber,
    output logic [15:0] ctrl_word
);
    logic [MDIO_AW-1:0] my_addr;
    logic [MDIO_AW-1:0] reg_addr;
    logic [MDIO_DW-1:0] rd_data;
    logic [MDIO_DW-1:0] wr_data;
    logic               wr_en;
    logic               rd_pulse;
    logic               link_latched;

    mdio_frame_rx #(
        .PRE_LEN (PRE_LEN),
        .AW      (MDIO_AW),
        .DW      (MDIO_DW)
    ) frame_i (
        .clk      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .my_addr  (my_addr),
        .rd_data  (rd_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_pulse (rd_pulse)
    );

    mdio_regbank #(
        .AW      (MDIO_AW),
        .DW      (MDIO_DW),
        .ID_HI   (ID_HI),
        .ID_LO   (ID_LO),
        .ABILITY (ABILITY)
    ) bank_i (
        .clk          (mdc),
        .rst_n        (rst_n),
        .strap_addr   (strap_addr),
        .addr         (reg_addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_pulse     (rd_pulse),
        .an_complete  (an_complete),
        .remote_fault (remote_fault),
        .link_up      (link_up),
        .jabber       (jabber),
        .rd_data      (rd_data),
        .ctrl_q       (ctrl_word),
        .my_addr      (my_addr),
        .link_latched (link_latched)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Module: protocol and register checker bound to the management slave.
// Watches the serial outputs, the control word and the link latch.
module mdio_mgmt_chk (
    input logic        mdc,
    input logic        rst_n,
    input logic        mdio_oe,
    input logic        mdio_out,
    input logic [15:0] ctrl_word,
    input logic [4:0]  strap_addr,
    input logic        link_up,
    input logic        rd_pulse,
    input logic        link_latched
);
    logic [5:0] oe_run;

    // Length of the current output-enable burst
    always_ff @(posedge mdc) begin
        if (!rst_n) oe_run <= '0;
        else if (mdio_oe) oe_run <= oe_run + 1'b1;
        else oe_run <= '0;
    end

    assert_ta_zero_R3: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    assert_oe_burst_R3: assert property (@(posedge mdc) disable iff (!rst_n)
        oe_run <= 6'd17);

    assert_reset_selfclr_R7: assert property (@(posedge mdc) disable iff (!rst_n)
        ctrl_word[15] |=> !ctrl_word[15]);

    assert_restart_selfclr_R7: assert property (@(posedge mdc) disable iff (!rst_n)
        ctrl_word[9] |=> !ctrl_word[9]);

    assert_strap_isolate_R5: assert property (@(posedge mdc) disable iff (!rst_n)
        (!$past(rst_n) && ($past(strap_addr) == 5'd0)) |-> ctrl_word[10]);

    assert_link_latch_R9: assert property (@(posedge mdc) disable iff (!rst_n)
        (!link_up && !rd_pulse) |=> !link_latched);
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk chk_i (
    .mdc          (mdc),
    .rst_n        (rst_n),
    .mdio_oe      (mdio_oe),
    .mdio_out     (mdio_out),
    .ctrl_word    (ctrl_word),
    .strap_addr   (strap_addr),
    .link_up      (link_up),
    .rd_pulse     (rd_pulse),
    .link_latched (link_latched)
);

// File: tb/mdio_mgmt_slave_tb_top.sv
// Bench: a behavioural station and reference model. Every bit period of
// every frame compares mdio_oe, mdio_out and ctrl_word with the model.
module mdio_mgmt_slave_tb_top;
    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_in = 1'b0;
    logic        mdio_out;
    logic        mdio_oe;
    logic [4:0]  strap_addr = 5'd5;
    logic        an_complete = 1'b0;
    logic        remote_fault = 1'b0;
    logic        link_up = 1'b0;
    logic        jabber = 1'b0;
    logic [15:0] ctrl_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    logic [15:0] m_ctrl;
    logic [15:0] m_adv;
    logic [4:0]  m_addr;
    logic        m_ll = 1'b0;

    always #5 mdc = ~mdc;

    mdio_mgmt_slave dut_i (
        .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .strap_addr(strap_addr), .an_complete(an_complete),
        .remote_fault(remote_fault), .link_up(link_up), .jabber(jabber),
        .ctrl_word(ctrl_word)
    );

    // Model of the latched-low link bit
    always @(posedge mdc) if (!rst_n || !link_up) m_ll = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [4:0] r);
        case (r)
            5'd0:  return m_ctrl;
            5'd1:  return {5'b01111, 5'b0, an_complete, remote_fault, 1'b1, m_ll, jabber, 1'b1};
            5'd2:  return 16'h0A5C;
            5'd3:  return 16'h3E21;
            5'd4:  return m_adv;
            5'd25: return {9'b0, ~m_ctrl[13], 1'b0, m_addr};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic do_reset(input logic [4:0] strap);
        @(negedge mdc);
        rst_n = 1'b0;
        strap_addr = strap;
        mdio_in = 1'b0;
        repeat (3) @(negedge mdc);
        rst_n = 1'b1;
        m_addr = strap;
        m_ctrl = 16'h3000 | ((strap == 5'd0) ? 16'h0400 : 16'h0000);
        m_adv = 16'h01E1;
        @(negedge mdc);
    endtask

    // One frame, with a check of the outputs in every bit period
    task automatic frame(input string tag, input int pre_len, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, output logic [15:0] rd);
        logic [31:0] tail;
        logic valid, hit_a, is_rd, is_wr, exp_oe;
        logic [15:0] exp_rd;
        tail  = {2'b01, op, phy, ra, 2'b10, (op == 2'b10) ? 16'hFFFF : wd};
        valid = (pre_len >= 32);
        hit_a = (phy == m_addr) || (phy == 5'd0);
        is_rd = valid && (op == 2'b10) && hit_a;
        is_wr = valid && (op == 2'b01) && hit_a;
        exp_rd = model_read(ra);
        rd = 16'h0000;
        for (int i = 0; i < pre_len; i++) begin
            chk(tag, "oe in preamble", {31'b0, mdio_oe}, 32'd0);
            mdio_in = 1'b1;
            @(negedge mdc);
        end
        for (int k = 0; k < 32; k++) begin
            exp_oe = is_rd && (k >= 15);
            chk(tag, "mdio_oe", {31'b0, mdio_oe}, {31'b0, exp_oe});
            chk(tag, "ctrl_word", {16'b0, ctrl_word}, {16'b0, m_ctrl});
            if (exp_oe && k == 15) chk(tag, "turnaround", {31'b0, mdio_out}, 32'd0);
            if (exp_oe && k >= 16) begin
                rd[31-k] = mdio_out;
                chk(tag, "read bit", {31'b0, mdio_out}, {31'b0, exp_rd[31-k]});
            end
            mdio_in = tail[31-k];
            @(negedge mdc);
        end
        mdio_in = 1'b0;
        if (is_wr && ra == 5'd0) m_ctrl = wd & 16'hFF80;
        if (is_wr && ra == 5'd4) m_adv = wd;
        if (is_rd && ra == 5'd1) m_ll = link_up;
        chk(tag, "oe released", {31'b0, mdio_oe}, 32'd0);
        chk(tag, "ctrl after frame", {16'b0, ctrl_word}, {16'b0, m_ctrl});
        m_ctrl = m_ctrl & ~16'h8200;
        @(negedge mdc);
        chk(tag, "ctrl next cycle", {16'b0, ctrl_word}, {16'b0, m_ctrl});
    endtask

    logic [15:0] r;

    initial begin
        do_reset(5'd5);
        chk("R5", "ctrl reset", {16'b0, ctrl_word}, 32'h3000);
        chk("R3", "oe reset", {31'b0, mdio_oe}, 32'd0);
        // R11 identifiers at own address and at broadcast (R2)
        frame("R11", 32, 2'b10, 5'd5, 5'd2, 16'h0, r);
        chk("R11", "id hi", {16'b0, r}, 32'h0A5C);
        frame("R2", 32, 2'b10, 5'd0, 5'd3, 16'h0, r);
        chk("R2", "broadcast id lo", {16'b0, r}, 32'h3E21);
        frame("R2", 32, 2'b10, 5'd6, 5'd2, 16'h0, r);
        // R4 strap word
        frame("R4", 40, 2'b10, 5'd5, 5'd25, 16'h0, r);
        chk("R4", "strap word", {16'b0, r}, 32'h0005);
        // R6 masked control write
        frame("R6", 32, 2'b01, 5'd5, 5'd0, 16'h01FF, r);
        frame("R6", 32, 2'b10, 5'd5, 5'd0, 16'h0, r);
        chk("R6", "ctrl readback", {16'b0, r}, 32'h0180);
        frame("R4", 32, 2'b10, 5'd5, 5'd25, 16'h0, r);
        chk("R4", "speed10 bit", {16'b0, r}, 32'h0045);
        // R7 self-clearing bits
        frame("R7", 32, 2'b01, 5'd0, 5'd0, 16'h9200, r);
        frame("R7", 32, 2'b10, 5'd5, 5'd0, 16'h0, r);
        chk("R7", "after selfclear", {16'b0, r}, 32'h1000);
        // R10 advertisement and reserved words
        frame("R10", 32, 2'b01, 5'd5, 5'd4, 16'hBEEF, r);
        frame("R10", 32, 2'b10, 5'd5, 5'd4, 16'h0, r);
        chk("R10", "adv readback", {16'b0, r}, 32'h0000BEEF);
        frame("R10", 32, 2'b01, 5'd5, 5'd8, 16'hFFFF, r);
        frame("R10", 32, 2'b10, 5'd5, 5'd8, 16'h0, r);
        chk("R10", "reserved 8", {16'b0, r}, 32'h0);
        frame("R10", 32, 2'b01, 5'd5, 5'd30, 16'hFFFF, r);
        frame("R10", 32, 2'b10, 5'd5, 5'd30, 16'h0, r);
        chk("R10", "reserved 30", {16'b0, r}, 32'h0);
        // R2 write to a foreign address is ignored
        frame("R2", 32, 2'b01, 5'd7, 5'd0, 16'h4100, r);
        frame("R2", 32, 2'b10, 5'd5, 5'd0, 16'h0, r);
        chk("R2", "ctrl untouched", {16'b0, r}, 32'h1000);
        // R1 bad opcodes and short preamble
        frame("R1", 32, 2'b11, 5'd5, 5'd2, 16'h0, r);
        frame("R1", 32, 2'b00, 5'd5, 5'd4, 16'h1234, r);
        frame("R1", 31, 2'b10, 5'd5, 5'd2, 16'h0, r);
        frame("R1", 31, 2'b01, 5'd5, 5'd4, 16'h5678, r);
        frame("R1", 32, 2'b10, 5'd5, 5'd4, 16'h0, r);
        chk("R1", "adv after rejected frames", {16'b0, r}, 32'h0000BEEF);
        // R8 and R9 status and link latch
        an_complete = 1'b1; jabber = 1'b1; link_up = 1'b1;
        frame("R9", 32, 2'b10, 5'd5, 5'd1, 16'h0, r);
        chk("R9", "first status read", {16'b0, r}, 32'h782B);
        frame("R8", 32, 2'b10, 5'd5, 5'd1, 16'h0, r);
        chk("R8", "status live", {16'b0, r}, 32'h782F);
        link_up = 1'b0;
        repeat (3) @(negedge mdc);
        link_up = 1'b1;
        remote_fault = 1'b1; jabber = 1'b0;
        frame("R9", 32, 2'b10, 5'd5, 5'd1, 16'h0, r);
        chk("R9", "latched low", {16'b0, r}, 32'h7839);
        frame("R9", 32, 2'b10, 5'd5, 5'd1, 16'h0, r);
        chk("R9", "reloaded", {16'b0, r}, 32'h783D);
        // R5 zero strap forces isolate
        do_reset(5'd0);
        chk("R5", "isolate on zero strap", {16'b0, ctrl_word}, 32'h3400);
        frame("R5", 32, 2'b10, 5'd0, 5'd0, 16'h0, r);
        chk("R5", "ctrl readback", {16'b0, r}, 32'h3400);
        frame("R4", 32, 2'b10, 5'd0, 5'd25, 16'h0, r);
        chk("R4", "zero strap word", {16'b0, r}, 32'h0000);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge mdc);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule